// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces the repeated-start condition for an I2C bus master. It drives open-drain SCL and SDA enables (a 1 pulls the line low) and watches the real line levels. A down-counter that the host reloads with a 7-bit value sets the timing. A phase whose length depends on SCL being high begins only after SCL is actually seen high, so a slave that stretches the clock delays the whole sequence. The host writes a 5-bit event-request register, where bit 1 is the repeated-start request and the other four bits are requests for other bus engines. It can also write a transmit buffer and clear the status flags.

While the sequence runs, the block refuses new event requests and buffer writes. A buffer write at that time raises a write-collision flag. The block watches the lines for a bus collision at two points. If one occurs it frees both lines and returns to idle without signalling completion. At normal completion the request bit clears itself, SDA stays driven low, and a completion flag is raised.

Top module: `i2c_rsen_seq`

## Requirements
- R1: A control write with bit 1 set is accepted only when the block is idle and `other_busy` is low. It then reads back as 1 in `evt_req[1]` and `scl_oe` goes to 1 on the next cycle. If `other_busy` is high, bit 1 stays 0 and `scl_oe` stays 0.
- R2: When the request is accepted, SCL is pulled low first, and SDA keeps its previous drive until SCL is sampled low. From the cycle after SCL is seen low, SDA is released and SCL is held low for `reload`+1 clocks. After that, SCL is released provided SDA is sampled high.
- R3: After SCL is released, the block waits for SCL to read high. Each clock of stretching delays every later edge by one clock.
- R4: Once SCL is seen high, both lines stay released for `reload`+1 clocks. SDA is then driven low for `reload`+1 clocks. SDA is never newly driven low while the SCL line is low.
- R5: At the end of the SDA-low period, `evt_req[1]` clears, `done_irq` goes to 1, and `sda_oe` stays 1 in idle.
- R6: `start_seen` goes to 1 one clock after SDA falls while SCL is high. At that moment `done_irq` is still 0.
- R7: A buffer write while idle loads `buf_q` on the next clock and leaves `wcol` alone. A buffer write during the sequence sets `wcol` and leaves `buf_q` unchanged.
- R8: Control writes during the sequence change none of the five `evt_req` bits.
- R9: If SDA reads low when SCL is first seen high after being released, `bcol` is set, both enables drop to 0, `evt_req[1]` clears, the block returns to idle, and `done_irq` is unchanged.
- R10: If SCL reads low during the both-lines-high period, the same abort as in R9 happens.
- R11: `flag_clr` clears `done_irq`, `wcol` and `bcol` on the next clock. A flag set in the same clock wins over the clear.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the event-request register |
| ctl_wdata | input | 5 | Event-request write data; bit 1 is the repeated-start request |
| other_busy | input | 1 | Another bus event is in progress |
| reload | input | 7 | Counter reload value; period is reload+1 clocks |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| flag_clr | input | 1 | Clears done_irq, wcol and bcol |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| evt_req | output | 5 | Event-request register contents |
| buf_q | output | 8 | Transmit buffer contents |
| start_seen | output | 1 | Start condition detected on the lines |
| done_irq | output | 1 | Repeated start completed |
| wcol | output | 1 | Buffer write collided with the sequence |
| bcol | output | 1 | Bus collision during the sequence |

## Verification
The hardest case to reach is the SDA-low-at-SCL-rise collision. The block releases SDA itself before it releases SCL, so the SDA fault has to be injected inside a narrow window. The bench stretches SCL externally to hold the block in its wait-for-high phase. It pulls SDA low during that wait and only then lets SCL rise. For the second collision, SCL is pulled low in the middle of a longer both-high period. The bench also times a sequence with a zero reload and a multi-clock stretch against edge cycles predicted from the reload and stretch values.

// File: rtl/i2c_rsen_seq.sv
module i2c_rsen_seq #(
  parameter int RLD_W = 7,
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [4:0]       ctl_wdata,
  input  logic             other_busy,
  input  logic [RLD_W-1:0] reload,
  input  logic             buf_wr,
  input  logic [DAT_W-1:0] buf_wdata,
  input  logic             flag_clr,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [4:0]       evt_req,
  output logic [DAT_W-1:0] buf_q,
  output logic             start_seen,
  output logic             done_irq,
  output logic             wcol,
  output logic             bcol
);
  localparam int RS_BIT = 1;

  typedef enum logic [2:0] {IDLE, SCL_LOW, SDA_HI, SCL_REL, BOTH_HI, SDA_LOW} st_t;
  st_t st;
  logic [RLD_W-1:0] cnt;
  logic sda_hold, scl_q, sda_q;
  wire busy    = (st != IDLE);
  wire expired = (cnt == '0);
  wire accept  = ctl_wr && ctl_wdata[RS_BIT] && !other_busy;

  assign scl_oe = (st == SCL_LOW) || (st == SDA_HI);
  assign sda_oe = (st == SDA_LOW) || sda_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      sda_hold <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      evt_req <= '0;
      buf_q <= '0;
      start_seen <= 1'b0;
      done_irq <= 1'b0;
      wcol <= 1'b0;
      bcol <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (scl_q && scl_in && sda_q && !sda_in) start_seen <= 1'b1;
      else if (scl_q && scl_in && !sda_q && sda_in) start_seen <= 1'b0;
      if (flag_clr) begin
        done_irq <= 1'b0;
        wcol <= 1'b0;
        bcol <= 1'b0;
      end
      if (buf_wr) begin
        if (busy) wcol <= 1'b1;
        else buf_q <= buf_wdata;
      end
      case (st)
        IDLE: if (ctl_wr) begin
          evt_req <= ctl_wdata;
          evt_req[RS_BIT] <= accept;
          if (accept) st <= SCL_LOW;
        end
        SCL_LOW: if (!scl_in) begin
          cnt <= reload;
          sda_hold <= 1'b0;
          st <= SDA_HI;
        end
        SDA_HI: begin
          if (!expired) cnt <= cnt - 1'b1;
          else if (sda_in) st <= SCL_REL;
        end
        SCL_REL: if (scl_in) begin
          if (!sda_in) begin
            bcol <= 1'b1;
            evt_req[RS_BIT] <= 1'b0;
            st <= IDLE;
          end else begin
            cnt <= reload;
            st <= BOTH_HI;
          end
        end
        BOTH_HI: begin
          if (!scl_in) begin
            bcol <= 1'b1;
            evt_req[RS_BIT] <= 1'b0;
            st <= IDLE;
          end else if (!expired) cnt <= cnt - 1'b1;
          else begin
            cnt <= reload;
            st <= SDA_LOW;
          end
        end
        SDA_LOW: begin
          if (!expired) cnt <= cnt - 1'b1;
          else begin
            evt_req[RS_BIT] <= 1'b0;
            done_irq <= 1'b1;
            sda_hold <= 1'b1;
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> ({evt_req[4:2], evt_req[0]} == $past({evt_req[4:2], evt_req[0]})));

  assert_wcol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buf_wr) |=> (wcol && $stable(buf_q)));

  assert_start_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_in);

  assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> (!busy && sda_oe && !evt_req[RS_BIT]));

  assert_bcol_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol) |-> (!scl_oe && !sda_oe && !evt_req[RS_BIT] && $stable(done_irq)));
endmodule

// File: tb/sim_i2c_rsen_seq.sv
module sim_i2c_rsen_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, other_busy = 1'b0, buf_wr = 1'b0, flag_clr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [6:0] reload = '0;
  logic [7:0] buf_wdata = '0;
  logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic scl_oe, sda_oe, start_seen, done_irq, wcol, bcol;
  logic [4:0] evt_req;
  logic [7:0] buf_q;
  wire scl_line = !(scl_oe || ext_scl_low);
  wire sda_line = !(sda_oe || ext_sda_low);

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {int cy; logic scl; logic sda; string tag;} exp_t;
  exp_t q[$];

  i2c_rsen_seq u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .other_busy(other_busy), .reload(reload), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .flag_clr(flag_clr), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .evt_req(evt_req),
    .buf_q(buf_q), .start_seen(start_seen), .done_irq(done_irq),
    .wcol(wcol), .bcol(bcol));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cy <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.cy < cyc) chk({e.tag, " missed slot"}, cyc, e.cy);
      else chk(e.tag, {30'd0, scl_oe, sda_oe}, {30'd0, e.scl, e.sda});
    end
  end

  task automatic to_cyc(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic push(input int cy, input logic s, input logic d, input string tag);
    exp_t e;
    e.cy = cy; e.scl = s; e.sda = d; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: request a repeated start and queue the expected enable edges
  task automatic go_rs(input int r, input int st, input logic hold, output int p0);
    reload = 7'(r);
    ctl_wdata = 5'b00010;
    ctl_wr = 1'b1;
    p0 = cyc + 1;
    push(p0, 1'b1, hold, "R1/R2 scl low first");
    if (hold) push(p0 + 1, 1'b1, 1'b0, "R2 sda released after scl low");
    push(p0 + r + 2 + st, 1'b0, 1'b0, "R2/R3 scl released");
    @(negedge clk);
    ctl_wr = 1'b0;
    ctl_wdata = '0;
  endtask

  task automatic clr_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
    chk("R11 flags cleared", {done_irq, wcol, bcol}, 3'b000);
  endtask

  initial begin
    int p0;
    int r;
    int s;
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {scl_oe, sda_oe, evt_req, buf_q, start_seen, done_irq, wcol, bcol}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    buf_wdata = 8'h55; buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
    chk("R7 idle buffer write", buf_q, 8'h55);
    chk("R7 no wcol in idle", wcol, 1'b0);

    other_busy = 1'b1; ctl_wdata = 5'b00010; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; other_busy = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ignored request bit", evt_req, 5'b00000);
    chk("R1 ignored no scl drive", scl_oe, 1'b0);

    r = 3;
    go_rs(r, 0, 1'b0, p0);
    push(p0 + 2*r + 4, 1'b0, 1'b1, "R4 sda low after both-high period");
    chk("R1 request accepted", evt_req, 5'b00010);
    to_cyc(p0 + 2);
    ctl_wdata = 5'b11101; ctl_wr = 1'b1;
    buf_wdata = 8'hAA; buf_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; buf_wr = 1'b0;
    chk("R7 wcol during sequence", wcol, 1'b1);
    chk("R7 buffer unchanged", buf_q, 8'h55);
    @(negedge clk);
    chk("R8 control write locked out", evt_req, 5'b00010);
    to_cyc(p0 + 2*r + 4);
    chk("R6 start not yet seen", start_seen, 1'b0);
    @(negedge clk);
    chk("R6 start seen", start_seen, 1'b1);
    chk("R6 irq not yet set", done_irq, 1'b0);
    to_cyc(p0 + 3*r + 4);
    chk("R5 irq before end", done_irq, 1'b0);
    @(negedge clk);
    chk("R5 irq at end", done_irq, 1'b1);
    chk("R5 request cleared", evt_req, 5'b00000);
    repeat (3) @(negedge clk);
    chk("R5 sda held low in idle", sda_oe, 1'b1);
    clr_flags();

    r = 0; s = 4;
    ext_scl_low = 1'b1;
    go_rs(r, s, 1'b1, p0);
    push(p0 + 2*r + 4 + s, 1'b0, 1'b1, "R3/R4 stretched sda low");
    to_cyc(p0 + r + 2 + s);
    chk("R3 still stretched", scl_oe, 1'b0);
    ext_scl_low = 1'b0;
    to_cyc(p0 + 3*r + 4 + s);
    chk("R3 irq not early", done_irq, 1'b0);
    @(negedge clk);
    chk("R3 irq after stretch", done_irq, 1'b1);
    clr_flags();

    r = 4;
    ext_scl_low = 1'b1;
    go_rs(r, 2, 1'b1, p0);
    to_cyc(p0 + r + 3);
    ext_sda_low = 1'b1;
    to_cyc(p0 + r + 4);
    ext_scl_low = 1'b0;
    @(negedge clk);
    chk("R9 bcol on sda low at scl rise", bcol, 1'b1);
    chk("R9 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R9 request cleared", evt_req, 5'b00000);
    chk("R9 no irq", done_irq, 1'b0);
    ext_sda_low = 1'b0;
    repeat (2) @(negedge clk);
    clr_flags();

    r = 5;
    go_rs(r, 0, 1'b0, p0);
    to_cyc(p0 + r + 4);
    ext_scl_low = 1'b1;
    @(negedge clk);
    chk("R10 bcol on scl low in both-high", bcol, 1'b1);
    chk("R10 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R10 request cleared", evt_req, 5'b00000);
    chk("R10 no irq", done_irq, 1'b0);
    ext_scl_low = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 idle after abort", scl_oe, 1'b0);
    chk("scoreboard drained", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule